// File: doc/BRIEF.md
# Serial Control-Frame Slave Endpoint

This block sits at the far end of a 16-slot time-division control link. A master sends one bit per slot on a serial command line, marks the last slot of every frame by pulling an active-low sync line for one bit time, and expects one status bit per slot back on a return line. The endpoint has no frame timing of its own. It waits for a sync pulse, takes that bit as slot 15, and then runs a free-running slot counter. It checks every later sync against that counter.

While aligned, the endpoint collects the command bits into a frame buffer. It commits the whole frame to a parallel word at once, on the falling edge that samples slot 15. On the return line it serializes its own status inputs by slot number: two groups of five modem-style lines, one power status bit, reserved slots, and an active-low presence flag. Any sync that comes in the wrong slot, or fails to come in slot 15, drops alignment. The endpoint then waits for a later sync.

Top module: `tdm_slave`

## Requirements
- R1: While `rst` is high at a clock edge, `locked` goes to 0, `tx_bit` goes to 1 and `cmd` goes to all zeros.
- R2: While not aligned, `tx_bit` is held at 1 and `locked` stays 0.
- R3: While not aligned, a 0 on `sync_n` sampled on a falling edge marks that bit as slot 15. `locked` rises at that falling edge, and the next bit is slot 0.
- R4: While aligned, `tx_bit` changes on the rising edge that starts each slot. It carries:
  - slots 0..4: `port_a[0..4]`
  - slots 5..9: `port_b[0..4]`
  - slot 10: `lan_pwr`
  - slot 15: `present_n`
- R5: While aligned, the reserved slots 11 to 14 drive `tx_bit` as 1.
- R6: `rx_bit` is sampled on the falling edge, and bit k of `cmd` holds the command bit of slot k. All 16 bits of `cmd` update together, at the falling edge that samples slot 15, but only if the endpoint was aligned and `sync_n` is 0 there.
- R7: While aligned, a 0 on `sync_n` in any slot other than 15 clears `locked` at that falling edge. That same bit does not realign the endpoint, and `tx_bit` returns to 1 from the next rising edge.
- R8: While aligned, a 1 on `sync_n` in slot 15 clears `locked`, and `cmd` keeps its previous value.
- R9: After alignment is lost, the next sync pulse restores alignment in the same way as R3. Frames then commit again.
- R10: `cmd` does not change while the endpoint is not aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one period per slot |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Frame marker from master, low during slot 15 |
| rx_bit | input | 1 | Serial command bit from master |
| port_a | input | 5 | Status lines of group A, bit k sent in slot k |
| port_b | input | 5 | Status lines of group B, bit k sent in slot 5+k |
| lan_pwr | input | 1 | Power status bit, sent in slot 10 |
| present_n | input | 1 | Active-low presence flag, sent in slot 15 |
| tx_bit | output | 1 | Serial status bit to master |
| cmd | output | 16 | Last committed command frame, bit k = slot k |
| locked | output | 1 | High while aligned to the frame |

## Verification
The return bit for a slot is due at the rising edge that opens that slot. The bench drives each bit 1 ns after a rising edge and reads `tx_bit` 2 ns after it, inside the same slot. Alignment and the command word change on the falling edge at mid-bit, so their new values can only be seen in the following bit period. For each bit the driver therefore queues the `tx_bit` value for that bit together with the `locked` and `cmd` values produced by the previous bit. The monitor pops the queue and compares on the same sampling tick.

// File: rtl/tdm_slave_pkg.sv
package tdm_slave_pkg;
    localparam int unsigned SLOTS     = 16;
    localparam int unsigned SW        = $clog2(SLOTS);
    localparam int unsigned LINES     = 5;
    localparam int unsigned LAN_SLOT  = 2 * LINES;

    typedef logic [SW-1:0]    slot_t;
    typedef logic [SLOTS-1:0] frame_t;

    localparam slot_t LAST_SLOT = slot_t'(SLOTS - 1);

    typedef struct packed {
        logic             present_n;
        logic             lan_pwr;
        logic [LINES-1:0] grp_b;
        logic [LINES-1:0] grp_a;
    } status_t;

    function automatic logic status_bit(status_t st, slot_t s);
        slot_t rel;
        logic  b;
        rel = s - slot_t'(LINES);
        if (s < slot_t'(LINES))            b = st.grp_a[s[2:0]];
        else if (s < slot_t'(LAN_SLOT))    b = st.grp_b[rel[2:0]];
        else if (s == slot_t'(LAN_SLOT))   b = st.lan_pwr;
        else if (s == LAST_SLOT)           b = st.present_n;
        else                               b = 1'b1;
        return b;
    endfunction
endpackage

// File: rtl/tdm_slave_align.sv
module tdm_slave_align
    import tdm_slave_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_n,
    output logic  lock_o,
    output slot_t slot_o,
    output logic  take_o,
    output logic  frame_end_o
);
    logic  lock_q;
    slot_t slot_q;
    logic  sync_bad;

    assign sync_bad    = (slot_q == LAST_SLOT) ? sync_n : !sync_n;
    assign take_o      = lock_q && !sync_bad;
    assign frame_end_o = take_o && (slot_q == LAST_SLOT);
    assign lock_o      = lock_q;
    assign slot_o      = slot_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            slot_q <= '0;
        end else if (!lock_q) begin
            if (!sync_n) begin
                lock_q <= 1'b1;
                slot_q <= '0;
            end
        end else if (sync_bad) begin
            lock_q <= 1'b0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // R3 / R9: sync while hunting aligns with slot 0 next
    a_r3_acquire: assert property (@(negedge clk) disable iff (rst)
        (!lock_q && !sync_n) |=> (lock_q && slot_q == '0));
    // R7: sync pulse in a wrong slot drops alignment
    a_r7_stray_sync: assert property (@(negedge clk) disable iff (rst)
        (lock_q && !sync_n && slot_q != LAST_SLOT) |=> !lock_q);
    // R8: missing sync in slot 15 drops alignment
    a_r8_missing_sync: assert property (@(negedge clk) disable iff (rst)
        (lock_q && sync_n && slot_q == LAST_SLOT) |=> !lock_q);
    // R2: no alignment without a sync pulse
    a_r2_stay_hunting: assert property (@(negedge clk) disable iff (rst)
        (!lock_q && sync_n) |=> !lock_q);
endmodule

// File: rtl/tdm_slave_capture.sv
module tdm_slave_capture
    import tdm_slave_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rx_i,
    input  slot_t  slot_i,
    input  logic   take_i,
    input  logic   frame_end_i,
    output frame_t cmd_o
);
    frame_t frame_q;
    frame_t cmd_q;
    frame_t frame_nx;

    always_comb begin
        frame_nx         = frame_q;
        frame_nx[slot_i] = rx_i;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            frame_q <= '0;
            cmd_q   <= '0;
        end else begin
            if (take_i)      frame_q <= frame_nx;
            if (frame_end_i) cmd_q   <= frame_nx;
        end
    end

    assign cmd_o = cmd_q;

    // R6 / R10 / R8: word only moves on a valid frame end
    a_r6_commit_only: assert property (@(negedge clk) disable iff (rst)
        !frame_end_i |=> $stable(cmd_q));
    // R6: last slot's bit lands in the top position of the word
    a_r6_last_bit: assert property (@(negedge clk) disable iff (rst)
        frame_end_i |=> (cmd_q[SLOTS-1] == $past(rx_i)));
endmodule

// File: rtl/tdm_slave_serializer.sv
module tdm_slave_serializer
    import tdm_slave_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    lock_i,
    input  slot_t   slot_i,
    input  status_t st_i,
    output logic    tx_o
);
    logic tx_q;

    always_ff @(posedge clk) begin
        if (rst)         tx_q <= 1'b1;
        else if (lock_i) tx_q <= status_bit(st_i, slot_i);
        else             tx_q <= 1'b1;
    end

    assign tx_o = tx_q;

    // R2: idle level while not aligned
    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        !lock_i |=> tx_q);
    // R5: reserved slots send ones
    a_r5_reserved_high: assert property (@(posedge clk) disable iff (rst)
        (lock_i && slot_i > slot_t'(LAN_SLOT) && slot_i != LAST_SLOT) |=> tx_q);
endmodule

// File: rtl/tdm_slave.sv
module tdm_slave
    import tdm_slave_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_n,
    input  logic             rx_bit,
    input  logic [LINES-1:0] port_a,
    input  logic [LINES-1:0] port_b,
    input  logic             lan_pwr,
    input  logic             present_n,
    output logic             tx_bit,
    output logic [SLOTS-1:0] cmd,
    output logic             locked
);
    logic    lock_w, take_w, end_w;
    slot_t   slot_w;
    status_t st_w;

    assign st_w = '{present_n: present_n, lan_pwr: lan_pwr,
                    grp_b: port_b, grp_a: port_a};

    tdm_slave_align u_align (
        .clk(clk), .rst(rst), .sync_n(sync_n),
        .lock_o(lock_w), .slot_o(slot_w), .take_o(take_w), .frame_end_o(end_w)
    );

    tdm_slave_capture u_capture (
        .clk(clk), .rst(rst), .rx_i(rx_bit), .slot_i(slot_w),
        .take_i(take_w), .frame_end_i(end_w), .cmd_o(cmd)
    );

    tdm_slave_serializer u_ser (
        .clk(clk), .rst(rst), .lock_i(lock_w), .slot_i(slot_w),
        .st_i(st_w), .tx_o(tx_bit)
    );

    assign locked = lock_w;
endmodule

// File: tb/tdm_slave_tb.sv
module tdm_slave_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_n = 1'b1;
    logic        rx_bit = 1'b0;
    logic [4:0]  port_a = 5'b0;
    logic [4:0]  port_b = 5'b0;
    logic        lan_pwr = 1'b0;
    logic        present_n = 1'b1;
    logic        tx_bit;
    logic [15:0] cmd;
    logic        locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tdm_slave u_dut (
        .clk(clk), .rst(rst), .sync_n(sync_n), .rx_bit(rx_bit),
        .port_a(port_a), .port_b(port_b), .lan_pwr(lan_pwr),
        .present_n(present_n), .tx_bit(tx_bit), .cmd(cmd), .locked(locked)
    );

    typedef struct {
        logic        tx;
        logic        lk;
        logic [15:0] cw;
        string       txtag;
        string       lktag;
        string       cwtag;
    } exp_t;
    exp_t sb[$];

    // reference state built from the requirements
    bit          m_lock = 0;
    int          m_slot = 0;
    logic [15:0] m_frame = '0;
    logic [15:0] m_cmd = '0;
    string       m_evt = "R2";
    bit          m_lost = 0;

    function automatic logic ref_tx(int s);
        case (s)
            0, 1, 2, 3, 4: return port_a[s];
            5, 6, 7, 8, 9: return port_b[s-5];
            10:            return lan_pwr;
            15:            return present_n;
            default:       return 1'b1;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic send_bit(logic s_n, logic d);
        exp_t e;
        @(posedge clk);
        #1;
        sync_n = s_n;
        rx_bit = d;
        e.tx    = m_lock ? ref_tx(m_slot) : 1'b1;
        e.txtag = !m_lock ? "R2" : (m_slot >= 11 && m_slot <= 14) ? "R5" : "R4";
        e.lk    = m_lock;
        e.lktag = m_evt;
        e.cw    = m_cmd;
        e.cwtag = m_lock ? "R6" : "R10";
        sb.push_back(e);
        if (!m_lock) begin
            if (!s_n) begin
                m_lock = 1; m_slot = 0;
                m_evt = m_lost ? "R9" : "R3";
            end
        end else if ((m_slot == 15) ? s_n : !s_n) begin
            m_lock = 0; m_lost = 1;
            m_evt = (m_slot == 15) ? "R8" : "R7";
        end else begin
            m_frame[m_slot] = d;
            if (m_slot == 15) m_cmd = m_frame;
            m_slot = (m_slot + 1) % 16;
        end
    endtask

    task automatic send_frame(logic [15:0] pat, bit drop_sync);
        for (int s = 0; s < 16; s++)
            send_bit((s == 15 && !drop_sync) ? 1'b0 : 1'b1, pat[s]);
    endtask

    // monitor: compares mid-bit, before the falling edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.txtag, {15'b0, tx_bit}, {15'b0, e.tx}, "tx_bit");
                check(e.lktag, {15'b0, locked}, {15'b0, e.lk}, "locked");
                check(e.cwtag, cmd, e.cw, "cmd");
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values
        check("R1", {15'b0, locked}, 16'h0, "locked");
        check("R1", {15'b0, tx_bit}, 16'h1, "tx_bit");
        check("R1", cmd, 16'h0, "cmd");
        @(posedge clk);
        #1;
        rst = 1'b0;
        // R2: hunting, no sync yet
        for (int i = 0; i < 6; i++) send_bit(1'b1, i[0]);
        // R3: first sync pulse
        port_a = 5'b10110; port_b = 5'b01001; lan_pwr = 1'b1; present_n = 1'b0;
        send_bit(1'b0, 1'b1);
        send_frame(16'hA5C3, 0);
        port_a = 5'b01001; port_b = 5'b10110; lan_pwr = 1'b0; present_n = 1'b1;
        send_frame(16'h0F1E, 0);
        port_a = 5'b11111; port_b = 5'b11111; lan_pwr = 1'b1;
        send_frame(16'hFFFF, 0);
        port_a = 5'b00000; port_b = 5'b00000; lan_pwr = 1'b0; present_n = 1'b0;
        send_frame(16'h0000, 0);
        // R7: stray sync in slot 5
        for (int s = 0; s < 5; s++) send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
        // R9: realign and commit again
        send_bit(1'b0, 1'b0);
        port_a = 5'b10101; port_b = 5'b01010;
        send_frame(16'h3C69, 0);
        // R8: missing sync, word held
        send_frame(16'h5555, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b0);
        send_frame(16'h8001, 0);
        send_bit(1'b1, 1'b0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule